// File: doc/BRIEF.md
# SMRAM Access Control Register and Window Decode

This block holds one 8-bit configuration register that guards the 128 KB system-management memory window at A0000h–BFFFFh. It also routes every memory access that touches that window. Software writes and reads the register through a byte-wide configuration port at offset 9Dh.

Each access is presented with its address, a management-mode flag and a code-fetch flag. The block answers combinationally whether the access goes to the protected DRAM or is forwarded to the downstream I/O link. The DRAM is never remapped: the block only chooses whether the window is visible.

Firmware typically uses the register in three steps:
1. It enables the window and sets the open bit while it initialises the protected memory.
2. It sets the lock bit. From then on the open bit is held low, and the enable and lock bits no longer accept writes until reset.
3. Inside management mode, the close bit lets data references fall through to the link while code fetches still reach the DRAM.

The decode path has no back-pressure. An access qualified by `acc_valid` is answered in the same cycle, and there is no ready signal because the block never stalls.

Top module: `smram_guard`

## Requirements
- R1: Synchronous active-high reset clears bits 7:3. A read at offset 9Dh then returns 02h, and a read at any other offset returns 00h.
- R2: A write at offset 9Dh updates bit 6 (OPEN), bit 5 (CLOSE), bit 4 (LOCK) and bit 3 (EN) on the next clock edge. Bit 7 always reads 0 and bits 2:0 always read 010b, whatever was written. A write at any other offset changes nothing.
- R3: The window is the address range A0000h–BFFFFh inclusive. An access outside it always goes to the link.
- R4: While EN is 0, every access in the window goes to the link.
- R5: With EN=1 and CLOSE=0, an in-window access with the management flag set goes to DRAM, for both code and data.
- R6: With EN=1 and CLOSE=1, an in-window data access (code flag 0) in management mode goes to the link, and a code fetch in management mode goes to DRAM. This holds even when OPEN is 1.
- R7: With EN=1, OPEN=1 and LOCK=0, an in-window access outside management mode goes to DRAM whatever CLOSE is. With OPEN=0 such an access goes to the link.
- R8: A write with bit 4 set makes LOCK 1 and OPEN 0, even if the same write sets bit 6. LOCK is then cleared only by reset.
- R9: While LOCK is 1, writes do not change OPEN, LOCK or EN, but CLOSE still follows bit 5 of each write.
- R10: With `acc_valid` high, exactly one of `acc_to_dram` and `acc_to_link` is high. With `acc_valid` low, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration offset for both read and write |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Combinational read data for `cfg_addr` |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_smm | input | 1 | Access issued in management mode |
| acc_code | input | 1 | Access is a code fetch (0 = data) |
| acc_to_dram | output | 1 | Route the access to protected DRAM |
| acc_to_link | output | 1 | Forward the access to the downstream link |

## Verification
A configuration write takes effect on the first rising edge on which the strobe is sampled high. Both the readback and the routing decision reflect the new value immediately after that edge. The readback and the route are combinational from the current register and the inputs, so they are due in the same cycle the inputs are applied. The bench drives inputs just after each rising edge and advances its reference model on that same edge. It compares every output at the falling edge, half a cycle later, when both the register and the combinational paths have settled.

// File: rtl/smram_pkg.sv
package smram_pkg;
  localparam int unsigned REG_W        = 8;
  localparam logic [7:0]  REG_OFFSET   = 8'h9D;
  localparam int unsigned BIT_OPEN     = 6;
  localparam int unsigned BIT_CLOSE    = 5;
  localparam int unsigned BIT_LOCK     = 4;
  localparam int unsigned BIT_EN       = 3;
  localparam logic [2:0]  BASE_SEG     = 3'b010;
  localparam logic [31:0] WIN_BASE     = 32'h000A_0000;
  localparam int unsigned WIN_SIZE_LOG2 = 17;

  typedef struct packed {
    logic open;
    logic close;
    logic lock;
    logic en;
  } smram_ctl_t;

  typedef enum logic [0:0] {
    ROUTE_LINK = 1'b0,
    ROUTE_DRAM = 1'b1
  } route_e;
endpackage

// File: rtl/smram_ctrl_reg.sv
module smram_ctrl_reg
  import smram_pkg::*;
#(
  parameter int unsigned DATA_W = REG_W,
  parameter logic [7:0]  OFFSET = REG_OFFSET
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output smram_ctl_t        ctl
);
  smram_ctl_t ctl_q;
  smram_ctl_t ctl_d;
  logic       hit;

  assign hit = (addr == OFFSET);

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en && hit) begin
      ctl_d.close = wdata[BIT_CLOSE];
      if (!ctl_q.lock) begin
        ctl_d.lock = wdata[BIT_LOCK];
        ctl_d.en   = wdata[BIT_EN];
        ctl_d.open = wdata[BIT_OPEN] & ~wdata[BIT_LOCK];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= ctl_d;
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      rdata[BIT_OPEN]  = ctl_q.open;
      rdata[BIT_CLOSE] = ctl_q.close;
      rdata[BIT_LOCK]  = ctl_q.lock;
      rdata[BIT_EN]    = ctl_q.en;
      rdata[2:0]       = BASE_SEG;
    end
  end

  assign ctl = ctl_q;
endmodule

// File: rtl/smram_window_decode.sv
module smram_window_decode
  import smram_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              smm,
  input  logic              code,
  input  smram_ctl_t        ctl,
  output logic              to_dram,
  output logic              to_link
);
  localparam int unsigned TAG_W = ADDR_W - WIN_SIZE_LOG2;
  localparam logic [TAG_W-1:0] WIN_TAG = TAG_W'(WIN_BASE >> WIN_SIZE_LOG2);

  logic   in_win;
  logic   smm_ok;
  logic   open_ok;
  route_e route;

  assign in_win  = (addr[ADDR_W-1:WIN_SIZE_LOG2] == WIN_TAG);
  assign smm_ok  = smm & (code | ~ctl.close);
  assign open_ok = ~smm & ctl.open & ~ctl.lock;

  always_comb begin
    route = ROUTE_LINK;
    if (ctl.en && in_win && (smm_ok || open_ok)) route = ROUTE_DRAM;
  end

  assign to_dram = valid & (route == ROUTE_DRAM);
  assign to_link = valid & (route == ROUTE_LINK);
endmodule

// File: rtl/smram_guard.sv
module smram_guard
  import smram_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_smm,
  input  logic              acc_code,
  output logic              acc_to_dram,
  output logic              acc_to_link
);
  smram_ctl_t ctl;

  smram_ctrl_reg #(.DATA_W(REG_W), .OFFSET(REG_OFFSET)) u_reg (
    .clk   (clk),
    .rst   (rst),
    .wr_en (cfg_wr_en),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .ctl   (ctl)
  );

  smram_window_decode #(.ADDR_W(ADDR_W)) u_dec (
    .valid   (acc_valid),
    .addr    (acc_addr),
    .smm     (acc_smm),
    .code    (acc_code),
    .ctl     (ctl),
    .to_dram (acc_to_dram),
    .to_link (acc_to_link)
  );
endmodule

// File: rtl/smram_guard_chk.sv
module smram_guard_chk
  import smram_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cfg_wr_en,
  input logic [7:0] cfg_addr,
  input logic [7:0] cfg_wdata,
  input logic       acc_valid,
  input logic       acc_smm,
  input logic       acc_code,
  input logic       acc_to_dram,
  input logic       acc_to_link,
  input smram_ctl_t ctl
);
  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    ctl.lock |=> ctl.lock);

  a_r8_open_low_locked: assert property (@(posedge clk) disable iff (rst)
    ctl.lock |-> !ctl.open);

  a_r9_en_frozen: assert property (@(posedge clk) disable iff (rst)
    ctl.lock |=> $stable(ctl.en));

  a_r2_other_offset: assert property (@(posedge clk) disable iff (rst)
    (cfg_addr != REG_OFFSET) |=> $stable(ctl));

  a_r4_disabled_link: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !ctl.en) |-> acc_to_link);

  a_r6_close_data: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_smm && !acc_code && ctl.close) |-> !acc_to_dram);

  a_r10_onehot: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> $onehot({acc_to_dram, acc_to_link}));

  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |-> !(acc_to_dram || acc_to_link));
endmodule

bind smram_guard smram_guard_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_addr    (cfg_addr),
  .cfg_wdata   (cfg_wdata),
  .acc_valid   (acc_valid),
  .acc_smm     (acc_smm),
  .acc_code    (acc_code),
  .acc_to_dram (acc_to_dram),
  .acc_to_link (acc_to_link),
  .ctl         (ctl)
);

// File: tb/smram_guard_test.sv
`timescale 1ns/1ps
module smram_guard_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_addr = 8'h9D;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = 32'h0;
  logic        acc_smm = 1'b0;
  logic        acc_code = 1'b0;
  logic        acc_to_dram;
  logic        acc_to_link;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  bit m_open, m_close, m_lock, m_en;

  always #2 clk = ~clk;

  smram_guard uut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_smm(acc_smm), .acc_code(acc_code),
    .acc_to_dram(acc_to_dram), .acc_to_link(acc_to_link)
  );

  // reference register model, advanced on the same edge as the design
  always @(posedge clk) begin
    if (rst) begin
      m_open = 0; m_close = 0; m_lock = 0; m_en = 0;
    end else if (cfg_wr_en && cfg_addr == 8'h9D) begin
      m_close = cfg_wdata[5];
      if (!m_lock) begin
        m_en = cfg_wdata[3];
        if (cfg_wdata[4]) begin
          m_lock = 1; m_open = 0;
        end else begin
          m_open = cfg_wdata[6];
        end
      end
    end
  end

  function automatic logic [7:0] exp_rd();
    if (cfg_addr != 8'h9D) return 8'h00;
    return {1'b0, m_open, m_close, m_lock, m_en, 3'b010};
  endfunction

  function automatic bit exp_dram();
    bit inside_win;
    inside_win = (acc_addr >= 32'hA0000) && (acc_addr <= 32'hBFFFF);
    if (!acc_valid || !m_en || !inside_win) return 0;
    if (acc_smm) begin
      if (acc_code) return 1;
      return !m_close;
    end
    return m_open && !m_lock;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2 readback", cfg_rdata, exp_rd());
      check("R10 route", {6'b0, acc_to_dram, acc_to_link},
            {6'b0, exp_dram(), acc_valid & ~exp_dram()});
    end
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(posedge clk); #1;
    cfg_wr_en = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr_en = 0; cfg_addr = 8'h9D;
  endtask

  task automatic rd_expect(string tag, logic [7:0] exp);
    @(negedge clk);
    check(tag, cfg_rdata, exp);
  endtask

  task automatic acc(string tag, logic [31:0] a, bit smm, bit code, bit dram);
    @(posedge clk); #1;
    acc_valid = 1; acc_addr = a; acc_smm = smm; acc_code = code;
    @(negedge clk);
    check(tag, {6'b0, acc_to_dram, acc_to_link}, {6'b0, dram, ~dram});
    @(posedge clk); #1;
    acc_valid = 0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1; rst = 1;
    repeat (2) @(posedge clk);
    #1; rst = 0;
  endtask

  initial begin
    do_reset();
    rd_expect("R1 reset readback", 8'h02);
    @(posedge clk); #1; cfg_addr = 8'h00;
    rd_expect("R1 other offset", 8'h00);
    @(posedge clk); #1; cfg_addr = 8'h9D;
    acc("R4 disabled smm data", 32'hA0000, 1, 0, 0);
    acc("R4 disabled open", 32'hB0000, 1, 1, 0);
    wr(8'h9D, 8'h88);
    rd_expect("R2 reserved bit masked", 8'h0A);
    wr(8'h9C, 8'h48);
    rd_expect("R2 other offset write ignored", 8'h0A);
    acc("R5 smm data low edge", 32'hA0000, 1, 0, 1);
    acc("R5 smm code high edge", 32'hBFFFF, 1, 1, 1);
    acc("R3 above window", 32'hC0000, 1, 1, 0);
    acc("R3 below window", 32'h9FFFF, 1, 1, 0);
    acc("R3 alias high bits", 32'h100A0000, 1, 1, 0);
    acc("R7 non-smm closed", 32'hA8000, 0, 0, 0);
    wr(8'h9D, 8'h48);
    acc("R7 non-smm open", 32'hA8000, 0, 0, 1);
    wr(8'h9D, 8'h68);
    rd_expect("R2 open+close", 8'h6A);
    acc("R7 open wins non-smm", 32'hA0010, 0, 0, 1);
    acc("R6 close wins smm data", 32'hA0010, 1, 0, 0);
    acc("R6 smm code under close", 32'hA0010, 1, 1, 1);
    wr(8'h9D, 8'h58);
    rd_expect("R8 lock forces open low", 8'h1A);
    acc("R8 non-smm after lock", 32'hA0000, 0, 0, 0);
    wr(8'h9D, 8'h40);
    rd_expect("R9 locked bits frozen", 8'h1A);
    wr(8'h9D, 8'h38);
    rd_expect("R9 close writable locked", 8'h3A);
    acc("R6 close under lock", 32'hA0000, 1, 0, 0);
    wr(8'h9D, 8'h00);
    rd_expect("R9 lock and en kept", 8'h1A);
    @(negedge clk);
    check("R10 idle", {6'b0, acc_to_dram, acc_to_link}, 8'h00);
    do_reset();
    rd_expect("R8 reset clears lock", 8'h02);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule